// File: doc/BRIEF.md
# Banked Configuration Register Space

This block holds the configuration registers of a multi-function peripheral controller. A host reaches them through a two-byte I/O window. Writing offset 0 sets a register index. Reading or writing offset 1 then reaches the register that index points at. Indices below 0x30 form a shared global area. It holds a read-only 16-bit identity and a revision byte, a logical-device select register and an exit control.

Indices from 0x30 upward are banked. Each implemented logical device owns a bank with these registers:
- an enable byte,
- two 16-bit I/O bases, stored big-endian,
- an IRQ number,
- a DMA channel.

The select register decides which bank the host sees.

Accesses take effect only while the unlock logic asserts the config-mode input. In that mode, writing the exit control with its request bit set sends a one-cycle pulse back to the unlock logic. One logical device can be built with a hard-wired enable value. Read data is registered and appears together with a valid strobe one clock after the read request.

Top module: `bcfg_regspace`

## Requirements
- R1: A write at offset 0 (host_addr=0) in config mode stores the byte as the current index. A read at offset 0 returns that index. Data accesses at offset 1 reach the register the index names.
- R2: Index 0x20 reads the high byte of DEV_ID, 0x21 its low byte and 0x22 reads REV_ID. Writes to these three indices are ignored.
- R3: Index 0x07 is a read/write select register. The bank seen at indices 0x30 and above belongs to the device whose number it holds, and each bank keeps its own values.
- R4: Index 0x30 is the bank's enable byte. Every bit is stored as written, so a single function bit can be set or cleared by rewriting the byte.
- R5: Each bank holds the following registers, all read/write:
  - a primary base at 0x60 (high byte) and 0x61 (low byte),
  - a secondary base at 0x62 (high) and 0x63 (low),
  - an IRQ byte at 0x70,
  - a DMA byte at 0x74.
  Other banked indices read 0x00.
- R6: The bank of device FORCE_LDN always reads FORCE_EN at index 0x30, and writes to that index do not change it.
- R7: While cfg_unlocked is low, every read returns 0xFF. Index writes and data writes change no state.
- R8: While the select register holds a number of NUM_DEV or more, indices 0x30 and above read 0xFF and writes to them change no bank.
- R9: A data write to index 0x02 with bit 1 set pulses cfg_exit high for exactly the following cycle. All other writes to indices 0x00 to 0x06 are ignored, and those indices read 0x00.
- R10: After reset the following hold:
  - the index and the select register are 0,
  - every enable byte is 0, except that the forced device reads FORCE_EN,
  - device d has primary base DEF_BASE0 + d*BASE_STRIDE, secondary base DEF_BASE1, IRQ DEF_IRQ + d and DMA DEF_DMA,
  - rd_valid and cfg_exit are low.
- R11: rd_valid is high in the cycle after each read request and low otherwise. host_rdata carries the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unlocked | input | 1 | Config mode granted by the unlock logic |
| host_addr | input | 1 | Window offset: 0 = index, 1 = data |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| rd_valid | output | 1 | host_rdata valid, one cycle after host_rd |
| cfg_exit | output | 1 | One-cycle exit request to the unlock logic |

## Verification
The bound checker watches several rules on every clock:
- the read handshake timing,
- the 0xFF answer to locked reads,
- the stability of the index while locked,
- the stability of the select register when no data write occurs,
- the rule that an exit pulse always follows a data write,
- the identity high byte.

Behaviours that depend on stored contents can only be shown by the bench's scenarios, because each needs a write followed by a read through the window:
- per-bank isolation,
- big-endian base layout,
- the hard-wired enable of the forced device,
- the dead bank behind an unimplemented device number,
- ignored writes to the identity and low global indices.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

  localparam logic [7:0] IX_EXIT    = 8'h02;
  localparam logic [7:0] IX_SEL     = 8'h07;
  localparam logic [7:0] IX_ID_HI   = 8'h20;
  localparam logic [7:0] IX_ID_LO   = 8'h21;
  localparam logic [7:0] IX_REV     = 8'h22;
  localparam logic [7:0] IX_BANK_LO = 8'h30;
  localparam int         EXIT_BIT   = 1;

  typedef enum logic [2:0] {
    F_NONE, F_EN, F_B0H, F_B0L, F_B1H, F_B1L, F_IRQ, F_DMA
  } bank_fld_e;

  typedef struct packed {
    logic [7:0]  en;
    logic [15:0] b0;
    logic [15:0] b1;
    logic [7:0]  irq;
    logic [7:0]  dma;
  } bank_t;

  // Map a banked index to the field it addresses.
  function automatic bank_fld_e fld_of(logic [7:0] ix);
    bank_fld_e f;
    case (ix)
      8'h30:   f = F_EN;
      8'h60:   f = F_B0H;
      8'h61:   f = F_B0L;
      8'h62:   f = F_B1H;
      8'h63:   f = F_B1L;
      8'h70:   f = F_IRQ;
      8'h74:   f = F_DMA;
      default: f = F_NONE;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bcfg_host_port.sv
module bcfg_host_port
  import bcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       unlocked,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic [7:0] mux_data,
  output logic [7:0] idx,
  output logic       reg_we,
  output logic [7:0] rdata,
  output logic       rvalid
);

  logic [7:0] idx_q;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  assign reg_we = wr & addr & unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
    end else if (wr && !addr && unlocked) begin
      idx_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) begin
        if (!unlocked)  rdata_q <= 8'hFF;
        else if (!addr) rdata_q <= idx_q;
        else            rdata_q <= mux_data;
      end
    end
  end

  assign idx    = idx_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/bcfg_global_regs.sv
module bcfg_global_regs
  import bcfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hB7C2,
  parameter logic [7:0]  REV_ID = 8'h15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] sel_ldn,
  output logic       exit_pulse,
  output logic [7:0] gl_rdata
);

  logic [7:0] sel_q;
  logic       exit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 8'h00;
      exit_q <= 1'b0;
    end else begin
      exit_q <= we && (idx == IX_EXIT) && wdata[EXIT_BIT];
      if (we && idx == IX_SEL) sel_q <= wdata;
    end
  end

  always_comb begin
    case (idx)
      IX_SEL:   gl_rdata = sel_q;
      IX_ID_HI: gl_rdata = DEV_ID[15:8];
      IX_ID_LO: gl_rdata = DEV_ID[7:0];
      IX_REV:   gl_rdata = REV_ID;
      default:  gl_rdata = 8'h00;
    endcase
  end

  assign sel_ldn    = sel_q;
  assign exit_pulse = exit_q;

endmodule

// File: rtl/bcfg_bank.sv
module bcfg_bank
  import bcfg_pkg::*;
#(
  parameter bit          FORCED   = 1'b0,
  parameter logic [7:0]  FORCE_EN = 8'h01,
  parameter logic [15:0] RST_B0   = 16'h0300,
  parameter logic [15:0] RST_B1   = 16'h0000,
  parameter logic [7:0]  RST_IRQ  = 8'h03,
  parameter logic [7:0]  RST_DMA  = 8'h04
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output bank_t      view
);

  bank_t r;

  always_ff @(posedge clk) begin
    if (rst) begin
      r.en  <= 8'h00;
      r.b0  <= RST_B0;
      r.b1  <= RST_B1;
      r.irq <= RST_IRQ;
      r.dma <= RST_DMA;
    end else if (we) begin
      case (fld_of(idx))
        F_EN:    if (!FORCED) r.en <= wdata;
        F_B0H:   r.b0[15:8] <= wdata;
        F_B0L:   r.b0[7:0]  <= wdata;
        F_B1H:   r.b1[15:8] <= wdata;
        F_B1L:   r.b1[7:0]  <= wdata;
        F_IRQ:   r.irq      <= wdata;
        F_DMA:   r.dma      <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    view = r;
    if (FORCED) view.en = FORCE_EN;
  end

endmodule

// File: rtl/bcfg_bank_file.sv
module bcfg_bank_file
  import bcfg_pkg::*;
#(
  parameter int          NUM_DEV     = 4,
  parameter int          FORCE_LDN   = 3,
  parameter logic [7:0]  FORCE_EN    = 8'h01,
  parameter logic [15:0] DEF_BASE0   = 16'h0300,
  parameter logic [15:0] BASE_STRIDE = 16'h0010,
  parameter logic [15:0] DEF_BASE1   = 16'h0000,
  parameter logic [7:0]  DEF_IRQ     = 8'h03,
  parameter logic [7:0]  DEF_DMA     = 8'h04
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  input  logic [7:0] sel_ldn,
  output logic [7:0] bk_rdata
);

  bank_t banks [NUM_DEV];
  logic  in_bank;

  assign in_bank = (idx >= IX_BANK_LO);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    localparam logic [15:0] B0  = 16'(DEF_BASE0 + g * BASE_STRIDE);
    localparam logic [7:0]  IRQ = 8'(DEF_IRQ + g);
    localparam bit          FRC = (g == FORCE_LDN);
    logic we_g;
    assign we_g = we && in_bank && (sel_ldn == 8'(g));
    bcfg_bank #(
      .FORCED(FRC), .FORCE_EN(FORCE_EN), .RST_B0(B0),
      .RST_B1(DEF_BASE1), .RST_IRQ(IRQ), .RST_DMA(DEF_DMA)
    ) u_bank (
      .clk(clk), .rst(rst), .we(we_g), .idx(idx),
      .wdata(wdata), .view(banks[g])
    );
  end

  bank_t pick;
  logic  hit;

  always_comb begin
    pick = banks[0];
    hit  = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (sel_ldn == 8'(d)) begin
        pick = banks[d];
        hit  = 1'b1;
      end
    end
    if (!hit) begin
      bk_rdata = 8'hFF;
    end else begin
      case (fld_of(idx))
        F_EN:    bk_rdata = pick.en;
        F_B0H:   bk_rdata = pick.b0[15:8];
        F_B0L:   bk_rdata = pick.b0[7:0];
        F_B1H:   bk_rdata = pick.b1[15:8];
        F_B1L:   bk_rdata = pick.b1[7:0];
        F_IRQ:   bk_rdata = pick.irq;
        F_DMA:   bk_rdata = pick.dma;
        default: bk_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/bcfg_regspace.sv
module bcfg_regspace
  import bcfg_pkg::*;
#(
  parameter int          NUM_DEV     = 4,
  parameter int          FORCE_LDN   = 3,
  parameter logic [7:0]  FORCE_EN    = 8'h01,
  parameter logic [15:0] DEV_ID      = 16'hB7C2,
  parameter logic [7:0]  REV_ID      = 8'h15,
  parameter logic [15:0] DEF_BASE0   = 16'h0300,
  parameter logic [15:0] BASE_STRIDE = 16'h0010,
  parameter logic [15:0] DEF_BASE1   = 16'h0000,
  parameter logic [7:0]  DEF_IRQ     = 8'h03,
  parameter logic [7:0]  DEF_DMA     = 8'h04
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_unlocked,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       rd_valid,
  output logic       cfg_exit
);

  logic [7:0] cur_idx;
  logic       reg_we;
  logic [7:0] sel_ldn;
  logic [7:0] gl_rdata;
  logic [7:0] bk_rdata;
  logic [7:0] mux_data;

  assign mux_data = (cur_idx >= IX_BANK_LO) ? bk_rdata : gl_rdata;

  bcfg_host_port u_port (
    .clk(clk), .rst(rst), .unlocked(cfg_unlocked), .addr(host_addr),
    .wr(host_wr), .rd(host_rd), .wdata(host_wdata), .mux_data(mux_data),
    .idx(cur_idx), .reg_we(reg_we), .rdata(host_rdata), .rvalid(rd_valid)
  );

  bcfg_global_regs #(.DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_glob (
    .clk(clk), .rst(rst), .we(reg_we), .idx(cur_idx), .wdata(host_wdata),
    .sel_ldn(sel_ldn), .exit_pulse(cfg_exit), .gl_rdata(gl_rdata)
  );

  bcfg_bank_file #(
    .NUM_DEV(NUM_DEV), .FORCE_LDN(FORCE_LDN), .FORCE_EN(FORCE_EN),
    .DEF_BASE0(DEF_BASE0), .BASE_STRIDE(BASE_STRIDE), .DEF_BASE1(DEF_BASE1),
    .DEF_IRQ(DEF_IRQ), .DEF_DMA(DEF_DMA)
  ) u_banks (
    .clk(clk), .rst(rst), .we(reg_we), .idx(cur_idx), .wdata(host_wdata),
    .sel_ldn(sel_ldn), .bk_rdata(bk_rdata)
  );

endmodule

// File: rtl/bcfg_checks.sv
module bcfg_checks #(
  parameter logic [15:0] DEV_ID = 16'hB7C2
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_unlocked,
  input logic       host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       rd_valid,
  input logic       cfg_exit,
  input logic [7:0] cur_idx,
  input logic [7:0] sel_ldn
);

  a_r11_valid_follows_rd: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> rd_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !rd_valid);

  a_r7_locked_read_ff: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !cfg_unlocked) |=> (host_rdata == 8'hFF));

  a_r7_index_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_unlocked |=> $stable(cur_idx));

  a_r3_select_holds: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr && cfg_unlocked) |=> $stable(sel_ldn));

  a_r9_exit_after_write: assert property (@(posedge clk) disable iff (rst)
    cfg_exit |-> $past(host_wr && host_addr && cfg_unlocked));

  a_r2_id_high: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && cfg_unlocked && host_addr && cur_idx == 8'h20)
      |=> (host_rdata == DEV_ID[15:8]));

endmodule

bind bcfg_regspace bcfg_checks #(.DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst(rst), .cfg_unlocked(cfg_unlocked), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .rd_valid(rd_valid), .cfg_exit(cfg_exit), .cur_idx(cur_idx),
  .sel_ldn(sel_ldn)
);

// File: tb/sim_bcfg_regspace.sv
`timescale 1ns/1ps
module sim_bcfg_regspace;

  localparam int          NDEV   = 4;
  localparam int          FLDN   = 3;
  localparam logic [7:0]  FEN    = 8'h01;
  localparam logic [15:0] ID     = 16'hB7C2;
  localparam logic [7:0]  REV    = 8'h15;
  localparam logic [15:0] B0DEF  = 16'h0300;
  localparam logic [15:0] STRIDE = 16'h0010;
  localparam logic [15:0] B1DEF  = 16'h0000;
  localparam logic [7:0]  IRQDEF = 8'h03;
  localparam logic [7:0]  DMADEF = 8'h04;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       unl = 1'b0;
  logic       addr = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rvalid;
  logic       cexit;

  always #2.5 clk = ~clk;

  bcfg_regspace #(
    .NUM_DEV(NDEV), .FORCE_LDN(FLDN), .FORCE_EN(FEN), .DEV_ID(ID),
    .REV_ID(REV), .DEF_BASE0(B0DEF), .BASE_STRIDE(STRIDE),
    .DEF_BASE1(B1DEF), .DEF_IRQ(IRQDEF), .DEF_DMA(DMADEF)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_unlocked(unl), .host_addr(addr),
    .host_wr(wr), .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
    .rd_valid(rvalid), .cfg_exit(cexit)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model of the register space
  logic [7:0]  m_idx;
  logic [7:0]  m_sel;
  logic [7:0]  m_en  [NDEV];
  logic [15:0] m_b0  [NDEV];
  logic [15:0] m_b1  [NDEV];
  logic [7:0]  m_irq [NDEV];
  logic [7:0]  m_dma [NDEV];

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_idx = 8'h00;
    m_sel = 8'h00;
    for (int d = 0; d < NDEV; d++) begin
      m_en[d]  = 8'h00;
      m_b0[d]  = 16'(B0DEF + d * STRIDE);
      m_b1[d]  = B1DEF;
      m_irq[d] = 8'(IRQDEF + d);
      m_dma[d] = DMADEF;
    end
  endfunction

  function automatic logic [7:0] exp_data(logic [7:0] ix);
    int s;
    if (ix < 8'h30) begin
      case (ix)
        8'h07:   return m_sel;
        8'h20:   return ID[15:8];
        8'h21:   return ID[7:0];
        8'h22:   return REV;
        default: return 8'h00;
      endcase
    end
    if (m_sel >= 8'(NDEV)) return 8'hFF;
    s = int'(m_sel);
    case (ix)
      8'h30:   return (s == FLDN) ? FEN : m_en[s];
      8'h60:   return m_b0[s][15:8];
      8'h61:   return m_b0[s][7:0];
      8'h62:   return m_b1[s][15:8];
      8'h63:   return m_b1[s][7:0];
      8'h70:   return m_irq[s];
      8'h74:   return m_dma[s];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(logic [7:0] ix, logic [7:0] d);
    int s;
    if (!unl) return;
    if (ix == 8'h07) m_sel = d;
    if (ix < 8'h30 || m_sel >= 8'(NDEV)) return;
    s = int'(m_sel);
    case (ix)
      8'h30: if (s != FLDN) m_en[s] = d;
      8'h60: m_b0[s][15:8] = d;
      8'h61: m_b0[s][7:0]  = d;
      8'h62: m_b1[s][15:8] = d;
      8'h63: m_b1[s][7:0]  = d;
      8'h70: m_irq[s] = d;
      8'h74: m_dma[s] = d;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] ix);
    if (!unl) return "R7";
    if (ix == 8'h07) return "R3";
    if (ix >= 8'h20 && ix <= 8'h22) return "R2";
    if (ix < 8'h30) return "R9";
    if (m_sel >= 8'(NDEV)) return "R8";
    if (ix == 8'h30) return (m_sel == 8'(FLDN)) ? "R6" : "R4";
    return "R5";
  endfunction

  task automatic wr_idx(logic [7:0] d);
    @(negedge clk); addr = 1'b0; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (unl) m_idx = d;
  endtask

  task automatic wr_dat(logic [7:0] d);
    logic ex;
    ex = unl && (m_idx == 8'h02) && d[1];
    @(negedge clk); addr = 1'b1; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R9 exit pulse", {7'd0, cexit}, {7'd0, ex});
    model_write(m_idx, d);
  endtask

  task automatic rd_at(logic a, string req);
    logic [7:0] e;
    e = !unl ? 8'hFF : (a ? exp_data(m_idx) : m_idx);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R11 rd_valid", {7'd0, rvalid}, 8'h01);
    chk(req, rdata, e);
  endtask

  task automatic rd_reg(logic [7:0] ix, string req);
    wr_idx(ix);
    rd_at(1'b1, req);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ix_pool [18];
    void'($urandom(32'd20240611));
    ix_pool = '{8'h00, 8'h02, 8'h05, 8'h07, 8'h07, 8'h20, 8'h21, 8'h22,
                8'h23, 8'h30, 8'h31, 8'h60, 8'h61, 8'h62, 8'h63, 8'h70,
                8'h74, 8'hFF};
    model_reset();
    repeat (4) @(negedge clk);
    chk("R10 rd_valid in reset", {7'd0, rvalid}, 8'h00);
    chk("R10 cfg_exit in reset", {7'd0, cexit}, 8'h00);
    rst = 1'b0;
    unl = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_at(1'b0, "R10 index after reset");
    rd_reg(8'h07, "R10 select after reset");
    rd_reg(8'h30, "R10 enable dev0");
    rd_reg(8'h60, "R10 base0 hi dev0");
    chk("R10 base0 hi literal", rdata, B0DEF[15:8]);
    rd_reg(8'h70, "R10 irq dev0");

    // R2 identity, read-only
    rd_reg(8'h20, "R2 id hi");
    chk("R2 id hi literal", rdata, 8'hB7);
    rd_reg(8'h21, "R2 id lo");
    rd_reg(8'h22, "R2 rev");
    wr_idx(8'h21); wr_dat(8'h00);
    rd_at(1'b1, "R2 id lo after write");
    chk("R2 id lo literal", rdata, 8'hC2);

    // R6 forced device
    wr_idx(8'h07); wr_dat(8'(FLDN));
    wr_idx(8'h30); wr_dat(8'hFE);
    rd_at(1'b1, "R6 forced enable");
    chk("R6 forced literal", rdata, FEN);

    // R4 enable bits, R5 bases big-endian, R3 bank isolation
    wr_idx(8'h07); wr_dat(8'h01);
    wr_idx(8'h30); wr_dat(8'h05);
    wr_dat(8'h04);
    rd_at(1'b1, "R4 enable clear bit0");
    wr_idx(8'h60); wr_dat(8'h12);
    wr_idx(8'h61); wr_dat(8'h34);
    rd_reg(8'h60, "R5 base0 hi");
    chk("R5 base0 hi literal", rdata, 8'h12);
    rd_reg(8'h61, "R5 base0 lo");
    wr_idx(8'h07); wr_dat(8'h00);
    rd_reg(8'h60, "R3 dev0 base unaffected");
    rd_reg(8'h30, "R3 dev0 enable unaffected");

    // R8 unimplemented device
    wr_idx(8'h07); wr_dat(8'h05);
    rd_reg(8'h30, "R8 dead bank read");
    wr_idx(8'h60); wr_dat(8'hAB);
    rd_at(1'b1, "R8 dead bank after write");
    wr_idx(8'h07); wr_dat(8'h01);
    rd_reg(8'h60, "R8 dev1 untouched");
    wr_idx(8'h07); wr_dat(8'h00);
    rd_reg(8'h60, "R8 dev0 untouched");

    // R9 exit control and ignored low globals
    wr_idx(8'h02); wr_dat(8'h02);
    @(negedge clk);
    chk("R9 exit one cycle", {7'd0, cexit}, 8'h00);
    wr_dat(8'h01);
    wr_idx(8'h05); wr_dat(8'h77);
    rd_at(1'b1, "R9 low global ignored");

    // R7 locked window, R1 index readback
    wr_idx(8'h07);
    unl = 1'b0;
    rd_at(1'b1, "R7 locked read");
    wr_idx(8'h60); wr_dat(8'h03);
    unl = 1'b1;
    rd_at(1'b0, "R1 index kept while locked");
    rd_at(1'b1, "R7 select unchanged");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] ix;
      op = $urandom_range(0, 39);
      ix = ix_pool[$urandom_range(0, 17)];
      if (op == 0) begin
        unl = ~unl;
      end else if (op < 12) begin
        wr_idx(ix);
      end else if (op < 22) begin
        if (m_idx == 8'h07) wr_dat(8'($urandom_range(0, 5)));
        else                wr_dat(8'($urandom));
      end else if (op < 37) begin
        rd_at(1'b1, tag_of(m_idx));
      end else begin
        rd_at(1'b0, unl ? "R1" : "R7");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule